// File: doc/BRIEF.md
# Serial Port Control and Status Register Unit

This block keeps the control and status state of a serial transceiver that can run in asynchronous or clocked mode. Software sets three control bits through a small register bus. One bit lets the transmit side run, one lets the receive side run, and one lets receive events raise interrupts. Five status flags report the state of the data path: transmit buffer empty, receive buffer full, framing error, parity error and overrun.

The bit serializer, baud generation and frame format are outside this block. The transmit shift engine sees a request level and the buffered word, and it returns a strobe when it takes the word. The receive shift engine sees a permission level. When a word is complete it delivers a strobe, the word and two error bits. Software clears a flag in two steps: it reads the flag as 1, then writes 0 to it.

Top module: `serctl_unit`

## Requirements
- R1: After reset the control bits are 0, the status register reads 0x01 (only the empty flag set), and the `irq_rx`, `irq_err` and `tx_req` outputs are 0.
- R2: Address 0 holds the control register. Bit 0 is receive enable, bit 1 is transmit enable and bit 2 is receive-interrupt enable. A write takes effect on the next cycle, and reads return the stored bits with 0 in the bits above.
- R3: While transmit enable is 0, the empty flag (status bit 0, address 1) reads 1, and a write to it has no effect.
- R4: `tx_req` is high exactly when transmit enable is 1 and the empty flag is 0. A write to address 2 stores the word that `tx_word` shows, and reads of address 2 return it. A `tx_take` strobe sets the empty flag to 1.
- R5: With receive enable at 1 and the full flag (status bit 1) at 0, an `rx_done` strobe loads `rx_word` into the receive buffer (read at address 3) and sets the full flag. It also sets the framing flag (bit 2) when `rx_frm_err` is high, and the parity flag (bit 3) when `rx_par_err` is high.
- R6: An accepted `rx_done` that arrives while the full flag is 1 sets the overrun flag (bit 4). The receive buffer, the framing flag and the parity flag keep their values.
- R7: While receive enable is 0, `rx_done` is ignored. Turning receive enable off leaves the full, framing, parity and overrun flags and the receive buffer as they were.
- R8: Writing 0 to a status bit clears that flag only if a status read returned it as 1 after it was last set. Writing 1 to a status bit never changes the flag. A setting event in the same cycle wins over a clear.
- R9: `irq_rx` equals receive-interrupt enable AND the full flag. `irq_err` equals receive-interrupt enable AND (framing OR parity OR overrun). Clearing the enable or the flags withdraws them.
- R10: `rx_go` follows receive enable. It is the receive engine's permission to begin a frame on a start bit or on an incoming serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| tx_req | output | 1 | Buffered word is ready for the transmit engine |
| tx_word | output | DATA_W | Transmit buffer contents |
| tx_take | input | 1 | Transmit engine took the word |
| rx_go | output | 1 | Receive engine may start a frame |
| rx_done | input | 1 | Receive engine finished a word |
| rx_word | input | DATA_W | Received word |
| rx_frm_err | input | 1 | Stop-bit error on the finished word |
| rx_par_err | input | 1 | Parity error on the finished word |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
The bench builds the unit with an 8-bit data width and the combinational read path (`READ_REG` = 0). This lets every read in a cycle be compared against the model within that same cycle. It also places a status read and a status write in neighbouring cycles, so the arm-then-clear order of each flag is exercised. Random writes to the control register turn the enables on and off during live traffic. This covers forced-empty entry and exit, receive events that arrive while reception is off, and overrun on top of a full buffer.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
   localparam int ADDR_W   = 2;
   localparam int NFLAGS   = 5;
   localparam int CTRL_W   = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
   localparam logic [ADDR_W-1:0] A_TXD  = 2'd2;
   localparam logic [ADDR_W-1:0] A_RXD  = 2'd3;

   localparam int F_TDE = 0;
   localparam int F_RDF = 1;
   localparam int F_FER = 2;
   localparam int F_PER = 3;
   localparam int F_OVR = 4;

   localparam int C_RXEN = 0;
   localparam int C_TXEN = 1;
   localparam int C_RIE  = 2;
endpackage

// File: rtl/serctl_ctrl_reg.sv
module serctl_ctrl_reg
   import serctl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic              rx_en,
   output logic              tx_en,
   output logic              rie
);
   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wdata[CTRL_W-1:0];
   end

   assign rx_en = ctrl_q[C_RXEN];
   assign tx_en = ctrl_q[C_TXEN];
   assign rie   = ctrl_q[C_RIE];
endmodule

// File: rtl/serctl_flag.sv
module serctl_flag #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_one,
   input  logic set_evt,
   input  logic rd_one,
   input  logic wr_zero,
   output logic flag_q
);
   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= INIT;
         arm_q  <= 1'b0;
      end else if (force_one) begin
         flag_q <= 1'b1;
         arm_q  <= 1'b0;
      end else if (set_evt) begin
         flag_q <= 1'b1;
      end else if (wr_zero && arm_q) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else if (rd_one) begin
         arm_q  <= 1'b1;
      end
   end
endmodule

// File: rtl/serctl_unit.sv
module serctl_unit
   import serctl_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tx_req,
   output logic [DATA_W-1:0] tx_word,
   input  logic              tx_take,
   output logic              rx_go,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              rx_frm_err,
   input  logic              rx_par_err,
   output logic              irq_rx,
   output logic              irq_err
);
   localparam int PAD_S = DATA_W - NFLAGS;
   localparam int PAD_C = DATA_W - CTRL_W;

   generate
      if (DATA_W < NFLAGS || DATA_W > 32) begin : g_bad_width
         $error("serctl_unit: DATA_W must lie in 5..32");
      end
   endgenerate

   logic rx_en_q, tx_en_q, rie_q;
   logic wr_ctrl, wr_stat, wr_txd, rd_stat, rx_acc;
   logic [NFLAGS-1:0] flag_q, stat_view, set_v, force_v;
   logic [DATA_W-1:0] tdr_q, rdr_q, rd_mux;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_stat = bus_wr && (bus_addr == A_STAT);
   assign wr_txd  = bus_wr && (bus_addr == A_TXD);
   assign rd_stat = bus_rd && (bus_addr == A_STAT);

   serctl_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_ctrl),
      .wdata (bus_wdata),
      .rx_en (rx_en_q),
      .tx_en (tx_en_q),
      .rie   (rie_q)
   );

   assign rx_acc = rx_done && rx_en_q;

   always_comb begin
      set_v        = '0;
      set_v[F_TDE] = tx_take;
      set_v[F_RDF] = rx_acc && !flag_q[F_RDF];
      set_v[F_FER] = rx_acc && !flag_q[F_RDF] && rx_frm_err;
      set_v[F_PER] = rx_acc && !flag_q[F_RDF] && rx_par_err;
      set_v[F_OVR] = rx_acc &&  flag_q[F_RDF];
      force_v        = '0;
      force_v[F_TDE] = !tx_en_q;
      stat_view        = flag_q;
      stat_view[F_TDE] = flag_q[F_TDE] || !tx_en_q;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NFLAGS; gi++) begin : g_flag
         serctl_flag #(.INIT(gi == F_TDE)) u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .force_one (force_v[gi]),
            .set_evt   (set_v[gi]),
            .rd_one    (rd_stat && stat_view[gi]),
            .wr_zero   (wr_stat && !bus_wdata[gi]),
            .flag_q    (flag_q[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdr_q <= '0;
         rdr_q <= '0;
      end else begin
         if (wr_txd) tdr_q <= bus_wdata;
         if (rx_acc && !flag_q[F_RDF]) rdr_q <= rx_word;
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_CTRL:  rd_mux = {{PAD_C{1'b0}}, rie_q, tx_en_q, rx_en_q};
         A_STAT:  rd_mux = {{PAD_S{1'b0}}, stat_view};
         A_TXD:   rd_mux = tdr_q;
         default: rd_mux = rdr_q;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rdata_q <= '0;
            else if (bus_rd) rdata_q <= rd_mux;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = bus_rd ? rd_mux : '0;
      end
   endgenerate

   assign tx_req  = tx_en_q && !flag_q[F_TDE];
   assign tx_word = tdr_q;
   assign rx_go   = rx_en_q;
   assign irq_rx  = rie_q && flag_q[F_RDF];
   assign irq_err = rie_q && (flag_q[F_FER] || flag_q[F_PER] || flag_q[F_OVR]);
endmodule

// File: rtl/serctl_chk.sv
module serctl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en_q,
   input logic              tx_en_q,
   input logic              rie_q,
   input logic [4:0]        flag_q,
   input logic [DATA_W-1:0] rdr_q,
   input logic              bus_wr,
   input logic [1:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              tx_take,
   input logic              rx_done,
   input logic [DATA_W-1:0] rx_word,
   input logic              irq_rx,
   input logic              irq_err
);
   logic stat_wr;
   assign stat_wr = bus_wr && (bus_addr == 2'd1);

   AST_TDE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en_q |=> flag_q[0]); // R3
   AST_TAKE_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |=> flag_q[0]); // R4
   AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_en_q && !flag_q[1]) |=> (flag_q[1] && rdr_q == $past(rx_word))); // R5
   AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_en_q && flag_q[1]) |=> (flag_q[4] && $stable(rdr_q))); // R6
   AST_RX_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en_q && !stat_wr) |=> ($stable(flag_q[4:1]) && $stable(rdr_q))); // R7
   AST_WRITE_ONE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && bus_wdata[1] && flag_q[1]) |=> flag_q[1]); // R8
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !rie_q |-> (!irq_rx && !irq_err)); // R9
endmodule

bind serctl_unit serctl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_en_q   (rx_en_q),
   .tx_en_q   (tx_en_q),
   .rie_q     (rie_q),
   .flag_q    (flag_q),
   .rdr_q     (rdr_q),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .tx_take   (tx_take),
   .rx_done   (rx_done),
   .rx_word   (rx_word),
   .irq_rx    (irq_rx),
   .irq_err   (irq_err)
);

// File: tb/tb_serctl_unit.sv
module tb_serctl_unit;
   localparam int CLK_P = 10;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0, bus_rdata;
   logic tx_req, tx_take = 1'b0, rx_go, rx_done = 1'b0;
   logic [DW-1:0] tx_word, rx_word = '0;
   logic rx_frm_err = 1'b0, rx_par_err = 1'b0, irq_rx, irq_err;

   int checks = 0;
   int fails = 0;

   logic m_rie, m_tx, m_rx;
   logic [4:0] m_f, m_a;
   logic [DW-1:0] m_tdr, m_rdr;

   always #(CLK_P/2) clk = ~clk;

   serctl_unit #(.DATA_W(DW), .READ_REG(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_req(tx_req), .tx_word(tx_word), .tx_take(tx_take), .rx_go(rx_go),
      .rx_done(rx_done), .rx_word(rx_word), .rx_frm_err(rx_frm_err),
      .rx_par_err(rx_par_err), .irq_rx(irq_rx), .irq_err(irq_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0:    return {5'b0, m_rie, m_tx, m_rx};
         2'd1:    return {3'b0, m_f[4:1], m_f[0] | ~m_tx};
         2'd2:    return m_tdr;
         default: return m_rdr;
      endcase
   endfunction

   task automatic model_tick(input logic wr, rd, input logic [1:0] a, input logic [DW-1:0] wd,
                             input logic take, done, input logic [DW-1:0] word, input logic fe, pe);
      logic [4:0] nf, na, setv, sr;
      logic acc;
      nf = m_f; na = m_a;
      sr = {m_f[4:1], m_f[0] | ~m_tx};
      acc = done & m_rx;
      setv = {acc & m_f[1], acc & ~m_f[1] & pe, acc & ~m_f[1] & fe, acc & ~m_f[1], take};
      for (int i = 0; i < 5; i++) begin
         if (i == 0 && !m_tx) begin nf[i] = 1'b1; na[i] = 1'b0; end
         else if (setv[i]) nf[i] = 1'b1;
         else if (wr && a == 2'd1 && !wd[i] && m_a[i]) begin nf[i] = 1'b0; na[i] = 1'b0; end
         else if (rd && a == 2'd1 && sr[i]) na[i] = 1'b1;
      end
      if (acc && !m_f[1]) m_rdr = word;
      if (wr && a == 2'd2) m_tdr = wd;
      if (wr && a == 2'd0) {m_rie, m_tx, m_rx} = wd[2:0];
      m_f = nf; m_a = na;
   endtask

   task automatic step(input logic wr, rd, input logic [1:0] a, input logic [DW-1:0] wd,
                       input logic take, done, input logic [DW-1:0] word, input logic fe, pe);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
      tx_take = take; rx_done = done; rx_word = word; rx_frm_err = fe; rx_par_err = pe;
      #1;
      if (rd) begin
         case (a)
            2'd0:    chk("R2 ctrl read", bus_rdata, exp_read(a));
            2'd1:    chk("R8 status read", bus_rdata, exp_read(a));
            2'd2:    chk("R4 txd read", bus_rdata, exp_read(a));
            default: chk("R5 rxd read", bus_rdata, exp_read(a));
         endcase
      end
      @(posedge clk);
      model_tick(wr, rd, a, wd, take, done, word, fe, pe);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; tx_take = 1'b0; rx_done = 1'b0;
      chk("R9 irq_rx", irq_rx, m_rie & m_f[1]);
      chk("R9 irq_err", irq_err, m_rie & (|m_f[4:2]));
      chk("R4 tx_req", tx_req, m_tx & ~m_f[0]);
      chk("R4 tx_word", tx_word, m_tdr);
      chk("R10 rx_go", rx_go, m_rx);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
      step(1'b1, 1'b0, a, d, 1'b0, 1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic rd_expect(input string tag, input logic [1:0] a, input logic [DW-1:0] e);
      bus_rd = 1'b1; bus_addr = a; #1;
      chk(tag, bus_rdata, e);
      step(1'b0, 1'b1, a, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic rx_word_in(input logic [DW-1:0] w, input logic fe, pe);
      step(1'b0, 1'b0, 2'd0, '0, 1'b0, 1'b1, w, fe, pe);
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] wd;
      int op;
      void'($urandom(32'h1f2e3d4c));
      m_rie = 0; m_tx = 0; m_rx = 0; m_f = 5'b00001; m_a = '0; m_tdr = '0; m_rdr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq_rx", irq_rx, 0);
      chk("R1 irq_err", irq_err, 0);
      chk("R1 tx_req", tx_req, 0);
      rd_expect("R1 ctrl", 2'd0, 8'h00);
      rd_expect("R1 status", 2'd1, 8'h01);
      // R3 empty flag pinned while transmit disabled
      rd_expect("R3 read", 2'd1, 8'h01);
      wr_reg(2'd1, 8'h00);
      rd_expect("R3 after write", 2'd1, 8'h01);
      // R8 clear needs prior read
      wr_reg(2'd0, 8'h03);
      wr_reg(2'd1, 8'h00);
      rd_expect("R8 no clear without read", 2'd1, 8'h01);
      wr_reg(2'd1, 8'h00);
      rd_expect("R8 clear after read", 2'd1, 8'h00);
      chk("R4 req", tx_req, 1);
      wr_reg(2'd2, 8'hA5);
      chk("R4 word", tx_word, 8'hA5);
      step(1'b0, 1'b0, 2'd0, '0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
      chk("R4 taken", tx_req, 0);
      // R5 receive and R9 masking
      rx_word_in(8'h3C, 1'b1, 1'b0);
      chk("R9 masked", irq_rx | irq_err, 0);
      rd_expect("R5 status", 2'd1, 8'h07);
      rd_expect("R5 data", 2'd3, 8'h3C);
      wr_reg(2'd0, 8'h07);
      chk("R9 irq_rx on", irq_rx, 1);
      chk("R9 irq_err on", irq_err, 1);
      // R6 overrun
      rx_word_in(8'hC3, 1'b0, 1'b1);
      rd_expect("R6 status", 2'd1, 8'h17);
      rd_expect("R6 data kept", 2'd3, 8'h3C);
      // R7 receive off
      wr_reg(2'd0, 8'h06);
      rx_word_in(8'h99, 1'b1, 1'b1);
      rd_expect("R7 flags kept", 2'd1, 8'h17);
      rd_expect("R7 data kept", 2'd3, 8'h3C);
      // R8 write ones ignored, write zero on bit 1 only
      wr_reg(2'd1, 8'hFD);
      rd_expect("R8 only full cleared", 2'd1, 8'h15);
      chk("R9 irq_rx off", irq_rx, 0);
      wr_reg(2'd0, 8'h02);
      chk("R9 rie off", irq_err, 0);
      // random traffic
      for (int n = 0; n < 4000; n++) begin
         op = $urandom % 8;
         wd = $urandom;
         case (op)
            0: step(1'b1, 1'b0, 2'd0, ($urandom % 4 == 0) ? wd : (wd | 8'h03),
                    1'b0, 1'b0, '0, 1'b0, 1'b0);
            1, 2: step(1'b0, 1'b1, 2'($urandom), '0, $urandom % 6 == 0, $urandom % 5 == 0,
                       8'($urandom), 1'($urandom), 1'($urandom));
            3: step(1'b1, 1'b0, 2'd1, ($urandom % 2) ? 8'h00 : wd, 1'b0, $urandom % 6 == 0,
                    8'($urandom), 1'($urandom), 1'($urandom));
            4: step(1'b1, 1'b0, 2'($urandom), wd, 1'b0, 1'b0, '0, 1'b0, 1'b0);
            5: step(1'b0, 1'b0, 2'd0, '0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
            default: step(1'b0, 1'b0, 2'd0, '0, 1'b0, 1'b1, 8'($urandom),
                          $urandom % 4 == 0, $urandom % 4 == 0);
         endcase
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule